// File: doc/BRIEF.md
# Split Doubleword Load-Store Unit

This unit carries out integer loads and stores for a 64-bit core whose data memory port is only 32 bits wide. The core presents a request with the access code (funct3), the base register value, a signed 12-bit offset and the store data. The unit adds the base and the sign-extended offset to form the effective address. It then drives one or two transactions on a request/ready bus that carries a size of 1, 2 or 4 bytes. When the access is finished it returns the load result, extended to 64 bits, together with a one-cycle done strobe.

A 64-bit access becomes two ordered word transactions. The low word always goes first at the effective address, and the high word follows at the effective address plus 4. For a load, the first word is held and the second word is joined above it. For a store, the 64-bit value is split into its two halves. Sub-word data sits right-aligned on both bus data paths. Access codes that the unit does not support are flagged as illegal and produce no bus activity.

Top module: `split_lsu`

## Requirements
- R1: The bus address of the first transaction equals the base value plus the 12-bit offset sign-extended to 64 bits.
- R2: The bus size is 1 for funct3[1:0]=00, 2 for funct3[1:0]=01 and 4 for funct3[1:0]=10 or 11.
- R3: Load codes 000, 001 and 010 sign-extend the byte, halfword or word to 64 bits. Load codes 100, 101 and 110 zero-extend it. Sub-word read data is taken from the low bits of the bus read data.
- R4: Load code 011 reads a word at the address and then a word at the address plus 4. The second word forms bits 63:32 of the result.
- R5: Store code 011 writes bits 31:0 at the address and then bits 63:32 at the address plus 4. Stores of codes 000 to 010 drive the store data right-aligned on the write data.
- R6: Only one transaction is outstanding at a time. Request, address, size, direction and write data hold steady until ready is seen, and a second transaction is issued only in the cycle after the first one completes.
- R7: Load code 111 and store codes 100 to 111 produce a one-cycle illegal pulse in the cycle after acceptance. They start no bus request and give no done pulse.
- R8: Done is high for exactly one cycle, in the cycle after the final ready. The load result updates with the done of a load and holds until the next load completes. Stores leave it unchanged.
- R9: A request is accepted only while the busy output is low. A request presented while busy is ignored.
- R10: After reset, the bus request, done, illegal and busy outputs are low and the load result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Access request (taken only while idle) |
| reqIsStore | input | 1 | 1 = store, 0 = load |
| reqFunct3 | input | 3 | Access code |
| reqBase | input | 64 | Base register value |
| reqOffset | input | 12 | Signed address offset |
| reqStoreData | input | 64 | Store data |
| busy | output | 1 | Access in progress |
| busReq | output | 1 | Bus transaction request |
| busWrite | output | 1 | 1 = write transaction |
| busAddr | output | 64 | Byte address of the transaction |
| busSize | output | 3 | Transaction size in bytes (1, 2 or 4) |
| busWdata | output | 32 | Write data, right-aligned |
| busReady | input | 1 | Transaction completes in this cycle |
| busRdata | input | 32 | Read data, right-aligned, valid with busReady |
| done | output | 1 | One-cycle completion strobe |
| illegal | output | 1 | One-cycle unsupported-code strobe |
| loadData | output | 64 | Extended load result |

## Verification
If the sequencer is in the wrong phase, the error shows up at once in the next cycle as a wrong busReq, a wrong busAddr (missing the +4 or carrying it too early) or a done pulse that comes too soon or too late. A fault in the captured address or data registers shows up in the first cycle of the bus request. A fault in the held low word or in the extension logic stays hidden until the done cycle of that load, where loadData differs from the value rebuilt from the bench memory. The bench compares every output against a behavioural model on every clock, so each of these faults is reported in the cycle it first appears.

// File: rtl/lsu_split_pkg.sv
package lsu_split_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} lsuState_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic capture;     // latch a legal request
    logic highHalf;    // second word of a doubleword is on the bus
    logic saveLow;     // keep the first read word
    logic loadFinish;  // update the load result
  } lsuStrobe_t;

  localparam logic [2:0] F3_DOUBLE = 3'b011;
  localparam logic [2:0] F3_LOAD_BAD = 3'b111;
endpackage

// File: rtl/lsu_split_ctrl.sv
module lsu_split_ctrl
  import lsu_split_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqIsStore,
  input  logic [2:0] reqFunct3,
  input  logic       busReady,
  output lsuStrobe_t strobe,
  output logic       busReq,
  output logic       busWrite,
  output logic       busy,
  output logic       done,
  output logic       illegal
);
  lsuState_e state;
  logic isStoreQ;
  logic isDoubleQ;
  logic legal;
  logic accept;
  logic lastBeat;

  assign legal  = reqIsStore ? (reqFunct3[2] == 1'b0) : (reqFunct3 != F3_LOAD_BAD);
  assign accept = (state == ST_IDLE) && reqValid;
  assign lastBeat = busReady && ((state == ST_HIGH) || ((state == ST_LOW) && !isDoubleQ));

  assign busy     = (state != ST_IDLE);
  assign busReq   = busy;
  assign busWrite = isStoreQ;

  assign strobe.capture    = accept && legal;
  assign strobe.highHalf   = (state == ST_HIGH);
  assign strobe.saveLow    = (state == ST_LOW) && busReady;
  assign strobe.loadFinish = lastBeat && !isStoreQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      isStoreQ  <= 1'b0;
      isDoubleQ <= 1'b0;
      done      <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            if (legal) begin
              state     <= ST_LOW;
              isStoreQ  <= reqIsStore;
              isDoubleQ <= (reqFunct3 == F3_DOUBLE);
            end else begin
              illegal <= 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (busReady) begin
            if (isDoubleQ) state <= ST_HIGH;
            else begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end
        end
        ST_HIGH: begin
          if (busReady) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lsu_split_datapath.sv
module lsu_split_datapath
  import lsu_split_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int BUS_W = 32,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  lsuStrobe_t       strobe,
  input  logic [2:0]       reqFunct3,
  input  logic [XLEN-1:0]  reqBase,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [XLEN-1:0]  reqStoreData,
  input  logic [BUS_W-1:0] busRdata,
  output logic [XLEN-1:0]  busAddr,
  output logic [2:0]       busSize,
  output logic [BUS_W-1:0] busWdata,
  output logic [XLEN-1:0]  loadData
);
  localparam int HALF_W = BUS_W / 2;
  localparam int BYTE_W = 8;
  localparam logic [XLEN-1:0] WORD_STEP = XLEN'(BUS_W / BYTE_W);

  logic [XLEN-1:0]  addrQ;
  logic [XLEN-1:0]  dataQ;
  logic [2:0]       f3Q;
  logic [BUS_W-1:0] lowQ;
  logic [XLEN-1:0]  extended;
  logic [XLEN-1:0]  offsetExt;

  assign offsetExt = {{(XLEN-OFF_W){reqOffset[OFF_W-1]}}, reqOffset};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      dataQ    <= '0;
      f3Q      <= '0;
      lowQ     <= '0;
      loadData <= '0;
    end else begin
      if (strobe.capture) begin
        addrQ <= reqBase + offsetExt;
        dataQ <= reqStoreData;
        f3Q   <= reqFunct3;
      end
      if (strobe.saveLow)    lowQ     <= busRdata;
      if (strobe.loadFinish) loadData <= extended;
    end
  end

  assign busAddr  = strobe.highHalf ? (addrQ + WORD_STEP) : addrQ;
  assign busWdata = strobe.highHalf ? dataQ[XLEN-1:BUS_W] : dataQ[BUS_W-1:0];

  always_comb begin
    case (f3Q[1:0])
      2'b00:   busSize = 3'd1;
      2'b01:   busSize = 3'd2;
      default: busSize = 3'd4;
    endcase
  end

  always_comb begin
    case (f3Q)
      3'b000:  extended = {{(XLEN-BYTE_W){busRdata[BYTE_W-1]}}, busRdata[BYTE_W-1:0]};
      3'b001:  extended = {{(XLEN-HALF_W){busRdata[HALF_W-1]}}, busRdata[HALF_W-1:0]};
      3'b010:  extended = {{(XLEN-BUS_W){busRdata[BUS_W-1]}}, busRdata};
      3'b011:  extended = {busRdata, lowQ};
      3'b100:  extended = {{(XLEN-BYTE_W){1'b0}}, busRdata[BYTE_W-1:0]};
      3'b101:  extended = {{(XLEN-HALF_W){1'b0}}, busRdata[HALF_W-1:0]};
      default: extended = {{(XLEN-BUS_W){1'b0}}, busRdata};
    endcase
  end
endmodule

// File: rtl/split_lsu.sv
module split_lsu
  import lsu_split_pkg::*;
#(
  parameter int XLEN  = 64,
  parameter int BUS_W = 32,
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqIsStore,
  input  logic [2:0]       reqFunct3,
  input  logic [XLEN-1:0]  reqBase,
  input  logic [OFF_W-1:0] reqOffset,
  input  logic [XLEN-1:0]  reqStoreData,
  output logic             busy,
  output logic             busReq,
  output logic             busWrite,
  output logic [XLEN-1:0]  busAddr,
  output logic [2:0]       busSize,
  output logic [BUS_W-1:0] busWdata,
  input  logic             busReady,
  input  logic [BUS_W-1:0] busRdata,
  output logic             done,
  output logic             illegal,
  output logic [XLEN-1:0]  loadData
);
  lsuStrobe_t strobe;

  lsu_split_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsStore(reqIsStore),
    .reqFunct3(reqFunct3), .busReady(busReady), .strobe(strobe),
    .busReq(busReq), .busWrite(busWrite), .busy(busy), .done(done),
    .illegal(illegal)
  );

  lsu_split_datapath #(.XLEN(XLEN), .BUS_W(BUS_W), .OFF_W(OFF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqFunct3(reqFunct3),
    .reqBase(reqBase), .reqOffset(reqOffset), .reqStoreData(reqStoreData),
    .busRdata(busRdata), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .loadData(loadData)
  );
endmodule

// File: rtl/split_lsu_checker.sv
module split_lsu_checker #(
  parameter int XLEN  = 64,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             busReq,
  input logic             busWrite,
  input logic [XLEN-1:0]  busAddr,
  input logic [2:0]       busSize,
  input logic [BUS_W-1:0] busWdata,
  input logic             busReady,
  input logic             done,
  input logic             illegal
);
  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busReady) |=> (busReq && $stable(busAddr) && $stable(busWdata) && $stable(busWrite) && $stable(busSize))); // R6
  AST_SIZE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busSize == 3'd1 || busSize == 3'd2 || busSize == 3'd4)); // R2
  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busReady) |=> (!busReq || (busAddr == $past(busAddr) + XLEN'(4) && busWrite == $past(busWrite)))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_AFTER_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(busReq && busReady)); // R8
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (!busReq && !done)); // R7
  AST_BUSY_COVERS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> busy); // R9
endmodule

bind split_lsu split_lsu_checker #(.XLEN(XLEN), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .busReq(busReq), .busWrite(busWrite),
  .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
  .busReady(busReady), .done(done), .illegal(illegal)
);

// File: tb/split_lsu_bench.sv
`timescale 1ns/1ps
module split_lsu_bench;
  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0;
  logic        reqIsStore = 0;
  logic [2:0]  reqFunct3 = 0;
  logic [63:0] reqBase = 0;
  logic [11:0] reqOffset = 0;
  logic [63:0] reqStoreData = 0;
  logic        busy, busReq, busWrite, done, illegal;
  logic [63:0] busAddr, loadData;
  logic [2:0]  busSize;
  logic [31:0] busWdata;
  logic        busReady = 0;
  logic [31:0] busRdata = 0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;  // 250 MHz

  split_lsu u_split_lsu (.*);

  // byte memory; unwritten bytes read as a fixed pattern
  logic [7:0] mem [logic [63:0]];

  function automatic logic [7:0] rdByte(input logic [63:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [31:0] rdBytes(input logic [63:0] a, input int n);
    logic [31:0] v = '0;
    for (int i = 0; i < n; i++) v[8*i +: 8] = rdByte(a + 64'(i));
    return v;
  endfunction

  function automatic int sizeOf(input logic [2:0] f3);
    return (f3[1:0] == 2'b00) ? 1 : (f3[1:0] == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [63:0] expLoad(input logic [63:0] a, input logic [2:0] f3);
    logic [31:0] w = rdBytes(a, sizeOf(f3));
    case (f3)
      3'b000: return {{56{w[7]}}, w[7:0]};
      3'b001: return {{48{w[15]}}, w[15:0]};
      3'b010: return {{32{w[31]}}, w};
      3'b011: return {rdBytes(a + 64'd4, 4), w};
      3'b100: return {56'd0, w[7:0]};
      3'b101: return {48'd0, w[15:0]};
      default: return {32'd0, w};
    endcase
  endfunction

  // behavioural reference model
  int          mPhase;
  logic [63:0] mAddr, mData, mExp, mLoad;
  logic [2:0]  mF3;
  logic        mStore, mDone, mIll;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPhase <= 0; mAddr <= 0; mData <= 0; mExp <= 0; mLoad <= 0;
      mF3 <= 0; mStore <= 0; mDone <= 0; mIll <= 0;
    end else begin
      mDone <= 0;
      mIll  <= 0;
      if (mPhase == 0) begin
        if (reqValid) begin
          logic ok;
          logic [63:0] ea;
          ok = reqIsStore ? (reqFunct3 < 3'd4) : (reqFunct3 != 3'd7);
          ea = reqBase + {{52{reqOffset[11]}}, reqOffset};
          if (!ok) mIll <= 1;
          else begin
            mPhase <= 1; mAddr <= ea; mF3 <= reqFunct3;
            mStore <= reqIsStore; mData <= reqStoreData;
            mExp <= expLoad(ea, reqFunct3);
          end
        end
      end else if (busReady) begin
        if (mStore) begin
          logic [63:0] a;
          logic [31:0] d;
          a = (mPhase == 2) ? mAddr + 64'd4 : mAddr;
          d = (mPhase == 2) ? mData[63:32] : mData[31:0];
          for (int i = 0; i < sizeOf(mF3); i++) mem[a + 64'(i)] = d[8*i +: 8];
        end
        if (mPhase == 1 && mF3 == 3'b011) mPhase <= 2;
        else begin
          mPhase <= 0; mDone <= 1;
          if (!mStore) mLoad <= mExp;
        end
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // per-cycle compare, then responder drive, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (rstN) begin
      logic [63:0] ea;
      ea = (mPhase == 2) ? mAddr + 64'd4 : mAddr;
      check(busReq == (mPhase != 0), "R6 busReq", 64'(busReq), 64'(mPhase != 0));
      check(busy == (mPhase != 0), "R9 busy", 64'(busy), 64'(mPhase != 0));
      check(done == mDone, "R8 done", 64'(done), 64'(mDone));
      check(illegal == mIll, "R7 illegal", 64'(illegal), 64'(mIll));
      check(loadData == mLoad, "R3 loadData", loadData, mLoad);
      if (mPhase != 0) begin
        check(busAddr == ea, "R1/R4 busAddr", busAddr, ea);
        check(busSize == 3'(sizeOf(mF3)), "R2 busSize", 64'(busSize), 64'(sizeOf(mF3)));
        check(busWrite == mStore, "R6 busWrite", 64'(busWrite), 64'(mStore));
        if (mStore) begin
          logic [31:0] d;
          logic [31:0] m;
          d = (mPhase == 2) ? mData[63:32] : mData[31:0];
          m = (sizeOf(mF3) == 1) ? 32'hFF : (sizeOf(mF3) == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
          check((busWdata & m) == (d & m), "R5 busWdata", 64'(busWdata & m), 64'(d & m));
        end
      end
    end
    busReady <= ((cyc % 5) != 2) && ((cyc % 7) != 3);
    busRdata <= rdBytes(busAddr, 4);
  end

  always @(posedge clk) if (cyc > 150000) begin
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  task automatic doOp(input logic st, input logic [2:0] f3, input logic [63:0] base,
                      input logic [11:0] off, input logic [63:0] data);
    @(negedge clk);
    reqValid = 1; reqIsStore = st; reqFunct3 = f3;
    reqBase = base; reqOffset = off; reqStoreData = data;
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 50 && !(done || illegal); i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(!busReq && !done && !illegal && !busy, "R10 reset outputs", 64'({busReq, done, illegal, busy}), 64'd0);
    check(loadData == 64'd0, "R10 reset loadData", loadData, 64'd0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // R3 sign and zero extension on pattern memory
    doOp(0, 3'b000, 64'h1000, 12'h000, 0);
    check(loadData == 64'hFFFF_FFFF_FFFF_FFA5, "R3 signed byte", loadData, 64'hFFFF_FFFF_FFFF_FFA5);
    doOp(0, 3'b100, 64'h1000, 12'h000, 0);
    check(loadData == 64'h0000_00A5, "R3 unsigned byte", loadData, 64'hA5);
    doOp(0, 3'b001, 64'h1000, 12'h002, 0);
    doOp(0, 3'b101, 64'h1000, 12'h002, 0);
    doOp(0, 3'b010, 64'h1000, 12'h004, 0);
    doOp(0, 3'b110, 64'h1000, 12'h004, 0);

    // R5 store word then positive byte/half loads
    doOp(1, 3'b010, 64'h2000, 12'h000, 64'hDEAD_BEEF_1234_5678);
    doOp(0, 3'b000, 64'h2000, 12'h000, 0);
    check(loadData == 64'h78, "R3 positive byte", loadData, 64'h78);
    doOp(1, 3'b000, 64'h2000, 12'h001, 64'h99);
    doOp(1, 3'b001, 64'h2000, 12'h002, 64'h8001);
    doOp(0, 3'b010, 64'h2000, 12'h000, 0);
    check(loadData == 64'hFFFF_FFFF_8001_9978, "R5 sub-word stores", loadData, 64'hFFFF_FFFF_8001_9978);

    // R4 R5 doubleword round trip with negative offset (R1)
    doOp(1, 3'b011, 64'h3010, 12'hFF0, 64'h8877_6655_4433_2211);
    doOp(0, 3'b011, 64'h3000, 12'h000, 0);
    check(loadData == 64'h8877_6655_4433_2211, "R4 doubleword load", loadData, 64'h8877_6655_4433_2211);
    doOp(0, 3'b010, 64'h3000, 12'h004, 0);
    check(loadData == 64'hFFFF_FFFF_8877_6655, "R5 high word at +4", loadData, 64'hFFFF_FFFF_8877_6655);
    doOp(0, 3'b110, 64'h3000, 12'h004, 0);
    check(loadData == 64'h8877_6655, "R3 unsigned word", loadData, 64'h8877_6655);

    // R7 illegal codes; R8 loadData held
    doOp(0, 3'b111, 64'h4000, 12'h000, 0);
    check(loadData == 64'h8877_6655, "R7 illegal load keeps result", loadData, 64'h8877_6655);
    doOp(1, 3'b101, 64'h3000, 12'h000, 64'h0);
    doOp(0, 3'b011, 64'h3000, 12'h000, 0);
    check(loadData == 64'h8877_6655_4433_2211, "R7 illegal store wrote nothing", loadData, 64'h8877_6655_4433_2211);

    // R9 request while busy is ignored
    @(negedge clk);
    reqValid = 1; reqIsStore = 0; reqFunct3 = 3'b011; reqBase = 64'h3000; reqOffset = 0;
    @(negedge clk);
    reqIsStore = 1; reqFunct3 = 3'b010; reqBase = 64'h3000; reqStoreData = 64'h0;
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 50 && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    doOp(0, 3'b011, 64'h3000, 12'h000, 0);
    check(loadData == 64'h8877_6655_4433_2211, "R9 busy request ignored", loadData, 64'h8877_6655_4433_2211);

    // mixed traffic
    for (int k = 0; k < 300; k++) begin
      logic st;
      logic [2:0] f3;
      st = 1'($urandom_range(0, 1));
      f3 = 3'($urandom_range(0, 7));
      doOp(st, f3, 64'h5000 + 64'($urandom_range(0, 63)), 12'($urandom_range(0, 4095)),
           {$urandom, $urandom});
    end
    repeat (5) @(negedge clk);
    finishRun();
  end
endmodule